// File: doc/BRIEF.md
# Register-Shifted Move Execute Unit

This block is the execute-stage datapath for a move whose second operand is shifted by an amount held in another register. On each accepted request it takes a 32-bit source operand, a 2-bit shift kind, a 32-bit amount register and the current N, Z, C and V flags. It applies a logical left, logical right, arithmetic right or rotate-right shift. One clock later it presents the shifted result, a register write-enable and the new flag values.

The shift amount is decided at run time, so it can exceed the operand width. The shifter produces a carry-out for every amount from 0 to 255, including zero and out-of-range amounts. A condition-passed qualifier suppresses all architectural effects. A set-flags control chooses whether N, Z and C are replaced. V is always passed through unchanged.

The control is a two-state machine. `ST_IDLE` means no result is presented. `ST_EMIT` means a result is presented for one cycle. From either state, `in_valid` high moves to `ST_EMIT`, and `in_valid` low moves to `ST_IDLE`. Reset forces `ST_IDLE`.

Top module: `rsm_exec`

## Requirements
- R1: The shift kind selects the operation: 00 logical left, 01 logical right, 10 arithmetic right, 11 rotate right. For an amount from 1 to 31, the result is the operand shifted by that amount, and the carry is the last bit shifted out.
- R2: Only bits [7:0] of `in_amount_reg` form the unsigned shift amount. Bits [31:8] have no effect on the result or the flags.
- R3: An amount of 0 returns the operand unchanged, with carry equal to the incoming C, for all four kinds.
- R4: A logical shift by exactly 32 gives a zero result. Its carry is operand bit 0 for a left shift and operand bit 31 for a right shift. A logical shift by more than 32 gives a zero result and a zero carry.
- R5: An arithmetic right shift by 32 or more fills every result bit with operand bit 31, and the carry equals operand bit 31.
- R6: A rotate right uses the amount modulo 32. For any nonzero amount, the carry is result bit 31. A nonzero multiple of 32 returns the operand unchanged.
- R7: Flag positions are [3]=N, [2]=Z, [1]=C, [0]=V on both `in_flags` and `out_flags`. When the condition passes and set-flags is high, N is result bit 31, Z is 1 exactly when the result is zero, C is the shifter carry, and `out_flags_wr` is 1.
- R8: `out_flags[0]` (V) always equals the V input of the request, whatever the controls are.
- R9: When `in_cond_pass` is low, `out_wr_en` and `out_flags_wr` are 0 and `out_flags` equals `in_flags`.
- R10: When the condition passes and set-flags is low, `out_wr_en` is 1, `out_flags_wr` is 0 and `out_flags` equals `in_flags`.
- R11: A request sampled with `in_valid` at a clock edge appears with `out_valid` high after that edge, for exactly the next cycle. Synchronous reset clears `out_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Request strobe; inputs are sampled while high |
| in_operand | input | 32 | Source operand to shift |
| in_amount_reg | input | 32 | Register holding the shift amount in bits [7:0] |
| in_kind | input | 2 | Shift kind code |
| in_cond_pass | input | 1 | Condition-passed qualifier |
| in_set_flags | input | 1 | Flag update request |
| in_flags | input | 4 | Current N, Z, C, V flags |
| out_valid | output | 1 | Result presented this cycle |
| out_result | output | 32 | Shifted result |
| out_wr_en | output | 1 | Destination register write enable |
| out_flags | output | 4 | New N, Z, C, V flags |
| out_flags_wr | output | 1 | N, Z and C were updated |

## Verification
Random operands are combined with amounts drawn from separate bands: zero, 1 to 31, exactly 32, 33 to 255, and random upper amount-register bits. This separates the in-range carry choice from the zero, boundary and saturated paths of each kind. Directed cases cover rotation by 32 and 64, arithmetic shifts of negative and positive operands past the width, and shifts that give a zero result. Those cases check the rotate carry rule, the sign fill and the Z flag. The controls are randomised on every request, so a result write is told apart from a flag update and a suppressed operation, and V is seen to pass through in every combination.

// File: rtl/rsm_pkg.sv
package rsm_pkg;

    typedef enum logic [1:0] {
        KIND_LSL = 2'b00,
        KIND_LSR = 2'b01,
        KIND_ASR = 2'b10,
        KIND_ROR = 2'b11
    } rsm_kind_e;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_EMIT = 1'b1
    } rsm_state_e;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } rsm_flags_t;

endpackage

// File: rtl/rsm_shifter.sv
module rsm_shifter
    import rsm_pkg::*;
#(
    parameter int W        = 32,
    parameter int AMT_BITS = 8
) (
    input  logic [W-1:0]        operand,
    input  logic [AMT_BITS-1:0] amount,
    input  rsm_kind_e           kind,
    input  logic                carry_in,
    output logic [W-1:0]        result,
    output logic                carry_out
);
    localparam int ROT_BITS = $clog2(W);

    logic [W:0]          ext_lsl;
    logic [W:0]          ext_lsr;
    logic signed [W:0]   ext_asr;
    logic [2*W-1:0]      ext_ror;
    logic [ROT_BITS-1:0] rot_amt;
    logic                amt_zero;

    assign amt_zero = (amount == '0);
    assign rot_amt  = amount[ROT_BITS-1:0];
    // An extra bit beyond the operand keeps the last bit shifted out.
    assign ext_lsl  = {1'b0, operand} << amount;
    assign ext_lsr  = {operand, 1'b0} >> amount;
    assign ext_asr  = $signed({operand, 1'b0}) >>> amount;
    assign ext_ror  = {operand, operand} >> rot_amt;

    always_comb begin
        result    = operand;
        carry_out = carry_in;
        if (!amt_zero) begin
            unique case (kind)
                KIND_LSL: begin
                    result    = ext_lsl[W-1:0];
                    carry_out = ext_lsl[W];
                end
                KIND_LSR: begin
                    result    = ext_lsr[W:1];
                    carry_out = ext_lsr[0];
                end
                KIND_ASR: begin
                    result    = ext_asr[W:1];
                    carry_out = ext_asr[0];
                end
                KIND_ROR: begin
                    result    = ext_ror[W-1:0];
                    carry_out = ext_ror[W-1];
                end
                default: begin
                    result    = operand;
                    carry_out = carry_in;
                end
            endcase
        end
    end

endmodule

// File: rtl/rsm_flag_unit.sv
module rsm_flag_unit
    import rsm_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] result,
    input  logic         carry,
    input  logic         cond_pass,
    input  logic         set_flags,
    input  rsm_flags_t   flags_in,
    output rsm_flags_t   flags_out,
    output logic         flags_wr,
    output logic         wr_en
);
    assign wr_en    = cond_pass;
    assign flags_wr = cond_pass && set_flags;

    always_comb begin
        flags_out = flags_in;
        if (flags_wr) begin
            flags_out.n = result[W-1];
            flags_out.z = (result == '0);
            flags_out.c = carry;
        end
    end

endmodule

// File: rtl/rsm_exec.sv
module rsm_exec
    import rsm_pkg::*;
#(
    parameter int W        = 32,
    parameter int AMT_BITS = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_valid,
    input  logic [W-1:0] in_operand,
    input  logic [W-1:0] in_amount_reg,
    input  logic [1:0]   in_kind,
    input  logic         in_cond_pass,
    input  logic         in_set_flags,
    input  logic [3:0]   in_flags,
    output logic         out_valid,
    output logic [W-1:0] out_result,
    output logic         out_wr_en,
    output logic [3:0]   out_flags,
    output logic         out_flags_wr
);
    rsm_state_e  state_q, state_nx;
    logic [W-1:0] sh_result;
    logic         sh_carry;
    rsm_flags_t   fl_next;
    logic         fl_wr;
    logic         wr_en_c;
    rsm_flags_t   flags_in_s;
    logic [AMT_BITS-1:0] amt_low;

    assign flags_in_s = rsm_flags_t'(in_flags);
    assign amt_low    = in_amount_reg[AMT_BITS-1:0];

    rsm_shifter #(.W(W), .AMT_BITS(AMT_BITS)) u_shifter (
        .operand   (in_operand),
        .amount    (amt_low),
        .kind      (rsm_kind_e'(in_kind)),
        .carry_in  (flags_in_s.c),
        .result    (sh_result),
        .carry_out (sh_carry)
    );

    rsm_flag_unit #(.W(W)) u_flags (
        .result    (sh_result),
        .carry     (sh_carry),
        .cond_pass (in_cond_pass),
        .set_flags (in_set_flags),
        .flags_in  (flags_in_s),
        .flags_out (fl_next),
        .flags_wr  (fl_wr),
        .wr_en     (wr_en_c)
    );

    always_comb begin
        unique case (state_q)
            ST_IDLE: state_nx = in_valid ? ST_EMIT : ST_IDLE;
            ST_EMIT: state_nx = in_valid ? ST_EMIT : ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_result   <= '0;
            out_wr_en    <= 1'b0;
            out_flags    <= '0;
            out_flags_wr <= 1'b0;
        end else if (in_valid) begin
            out_result   <= sh_result;
            out_wr_en    <= wr_en_c;
            out_flags    <= fl_next;
            out_flags_wr <= fl_wr;
        end
    end

    assign out_valid = (state_q == ST_EMIT);

    // R11: one-cycle latency, valid for exactly one cycle per strobe
    p_latency_r11: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    p_drop_r11: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);
    // R8: V passes through
    p_v_kept_r8: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_flags[0] == $past(in_flags[0]));
    // R9: failed condition has no effect
    p_no_effect_r9: assert property (@(posedge clk) disable iff (rst)
        in_valid && !in_cond_pass |=>
            !out_wr_en && !out_flags_wr && out_flags == $past(in_flags));
    // R10: write without flag update
    p_keep_flags_r10: assert property (@(posedge clk) disable iff (rst)
        in_valid && in_cond_pass && !in_set_flags |=>
            out_wr_en && !out_flags_wr && out_flags == $past(in_flags));
    // R7: N and Z follow the presented result
    p_nz_r7: assert property (@(posedge clk) disable iff (rst)
        out_valid && out_flags_wr |->
            out_flags[3] == out_result[W-1] && out_flags[2] == (out_result == '0));
    // R3: zero amount leaves the operand unchanged
    p_zero_amt_r3: assert property (@(posedge clk) disable iff (rst)
        in_valid && amt_low == '0 |=> out_result == $past(in_operand));

endmodule

// File: tb/test_rsm_exec.sv
module test_rsm_exec;
    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [31:0] in_operand;
    logic [31:0] in_amount_reg;
    logic [1:0]  in_kind;
    logic        in_cond_pass;
    logic        in_set_flags;
    logic [3:0]  in_flags;
    logic        out_valid;
    logic [31:0] out_result;
    logic        out_wr_en;
    logic [3:0]  out_flags;
    logic        out_flags_wr;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    rsm_exec i_rsm_exec (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_operand(in_operand),
        .in_amount_reg(in_amount_reg), .in_kind(in_kind),
        .in_cond_pass(in_cond_pass), .in_set_flags(in_set_flags),
        .in_flags(in_flags), .out_valid(out_valid), .out_result(out_result),
        .out_wr_en(out_wr_en), .out_flags(out_flags), .out_flags_wr(out_flags_wr)
    );

    // Reference shifter written bit by bit from the requirements.
    function automatic logic [32:0] ref_shift(input logic [31:0] op,
                                              input logic [7:0] amt,
                                              input logic [1:0] kind,
                                              input logic cin);
        logic [31:0] r;
        logic c;
        r = op;
        c = cin;
        for (int i = 0; i < int'(amt); i++) begin
            case (kind)
                2'b00: begin c = r[31]; r = {r[30:0], 1'b0}; end
                2'b01: begin c = r[0];  r = {1'b0, r[31:1]}; end
                2'b10: begin c = r[0];  r = {r[31], r[31:1]}; end
                default: begin r = {r[0], r[31:1]}; c = r[31]; end
            endcase
        end
        return {c, r};
    endfunction

    function automatic string tag_of(input logic [1:0] kind, input logic [7:0] amt,
                                     input logic [31:0] areg);
        if (areg[31:8] != 0 && amt != 0) return "R2";
        if (amt == 0) return "R3";
        if (kind == 2'b11) return "R6";
        if (amt >= 32) return (kind == 2'b10) ? "R5" : "R4";
        return "R1";
    endfunction

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic run_op(input logic [31:0] op, input logic [31:0] areg,
                          input logic [1:0] kind, input logic cp,
                          input logic sf, input logic [3:0] fl);
        logic [32:0] rs;
        logic [3:0]  ef;
        string tg;
        rs = ref_shift(op, areg[7:0], kind, fl[1]);
        tg = tag_of(kind, areg[7:0], areg);
        ef = fl;
        if (cp && sf) ef = {rs[31], rs[31:0] == 0, rs[32], fl[0]};
        @(negedge clk);
        in_valid = 1'b1; in_operand = op; in_amount_reg = areg;
        in_kind = kind; in_cond_pass = cp; in_set_flags = sf; in_flags = fl;
        @(negedge clk);
        in_valid = 1'b0;
        check("R11", "out_valid", 64'(out_valid), 64'd1);
        if (cp) check(tg, "result", 64'(out_result), 64'(rs[31:0]));
        check(cp ? (sf ? "R7" : "R10") : "R9", "wr_en", 64'(out_wr_en), 64'(cp));
        check(cp && sf ? "R7" : (cp ? "R10" : "R9"), "flags_wr",
              64'(out_flags_wr), 64'(cp && sf));
        check(cp && sf ? tg : (cp ? "R10" : "R9"), "flags", 64'(out_flags), 64'(ef));
        check("R8", "V flag", 64'(out_flags[0]), 64'(fl[0]));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual running expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] op, areg;
        logic [7:0]  a;
        void'($urandom(32'h5EED_1234));
        rst = 1'b1; in_valid = 1'b0; in_operand = '0; in_amount_reg = '0;
        in_kind = '0; in_cond_pass = 1'b0; in_set_flags = 1'b0; in_flags = '0;
        repeat (3) @(negedge clk);
        check("R11", "reset out_valid", 64'(out_valid), 64'd0);
        rst = 1'b0;

        // Directed corners
        for (int k = 0; k < 4; k++) begin
            run_op(32'h8000_0001, 32'd0,  2'(k), 1, 1, 4'b0010); // R3 carry in 1
            run_op(32'h8000_0001, 32'd0,  2'(k), 1, 1, 4'b0101); // R3 carry in 0
            run_op(32'h8000_0001, 32'd32, 2'(k), 1, 1, 4'b0000); // R4 R5 R6
            run_op(32'h7FFF_FFFE, 32'd32, 2'(k), 1, 1, 4'b0011);
            run_op(32'hC000_0003, 32'd33, 2'(k), 1, 1, 4'b0010);
            run_op(32'hC000_0003, 32'd255, 2'(k), 1, 1, 4'b0010);
        end
        run_op(32'h1234_5678, 32'd64, 2'b11, 1, 1, 4'b0000);     // R6 multiple of 32
        run_op(32'h0000_0001, 32'd1,  2'b01, 1, 1, 4'b0000);     // R7 Z and C
        run_op(32'hDEAD_BEEF, 32'hFFFF_FF00, 2'b00, 1, 1, 4'b0010); // R2 amount 0 via low byte
        run_op(32'hDEAD_BEEF, 32'h0000_0104, 2'b01, 1, 1, 4'b0000); // R2
        run_op(32'hDEAD_BEEF, 32'd4, 2'b00, 0, 1, 4'b1011);      // R9
        run_op(32'hDEAD_BEEF, 32'd4, 2'b00, 1, 0, 4'b0110);      // R10

        @(negedge clk);
        check("R11", "valid drops", 64'(out_valid), 64'd0);

        // Random requests with banded amounts
        for (int i = 0; i < 600; i++) begin
            op = $urandom;
            case ($urandom % 5)
                0: a = 8'd0;
                1: a = 8'(1 + $urandom % 31);
                2: a = 8'd32;
                3: a = 8'(33 + $urandom % 223);
                default: a = 8'($urandom);
            endcase
            areg = {(($urandom % 3) == 0) ? 24'($urandom) : 24'd0, a};
            run_op(op, areg, 2'($urandom), ($urandom % 4) != 0,
                   1'($urandom), 4'($urandom));
        end

        // Reset in the middle clears out_valid (R11)
        @(negedge clk);
        in_valid = 1'b1; rst = 1'b1;
        @(negedge clk);
        in_valid = 1'b0; rst = 1'b0;
        check("R11", "valid after reset", 64'(out_valid), 64'd0);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule